// File: doc/BRIEF.md
# Dual-Port Memory Mailbox Interrupt Controller

This block produces the two cross-port interrupt flags for a dual-ported memory of 2K bytes. It watches the access controls of both ports. It does not store data or arbitrate between the ports.

Each port owns one mailbox address at the top of memory. When the opposite port writes that address, the owning port is flagged. When the owning port reads its own mailbox, its flag is cleared. The mailbox bytes stay ordinary memory in the array beside this block. Only the flags live here.

A port that its arbiter is holding off, shown by its hold input being low, causes neither a set nor a clear. A global enable turns the mailbox mechanism off. While it is off, both mailbox addresses behave as plain memory.

All inputs are sampled on the rising clock edge. Each flag is one register, so an interrupt pin changes one clock after the access that causes the change.

Top module: `dual_port_mailbox_irq`

## Requirements
- R1: Addresses are 11 bits wide. When the left port writes address 0x7FF (l_sel_n=0, l_we_n=0, l_hold_n=1, irq_en=1), the right flag is set, and r_irq_n reads 0 after the next rising edge.
- R2: When the right port writes address 0x7FE (r_sel_n=0, r_we_n=0, r_hold_n=1, irq_en=1), the left flag is set, and l_irq_n reads 0 after the next rising edge.
- R3: When the left port accesses 0x7FE with l_sel_n=0, l_oe_n=0 and l_hold_n=1, the left flag is cleared, and l_irq_n reads 1 after the next edge. The value of l_we_n does not matter.
- R4: When the right port accesses 0x7FF with r_sel_n=0, r_oe_n=0 and r_hold_n=1, the right flag is cleared, and r_irq_n reads 1 after the next edge.
- R5: If the acting port's hold input is 0, the set or clear it would cause is skipped, and the flag keeps its value.
- R6: If a set and a clear of the same flag fall in the same cycle, the set wins.
- R7: After reset, both flags are clear, so l_irq_n=1 and r_irq_n=1.
- R8: While irq_en=0, both flags are cleared one edge later and stay clear, and no mailbox access sets them.
- R9: None of the following changes a flag:
  - accesses to any other address;
  - a port writing its own mailbox;
  - a mailbox read with the output enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_en | input | 1 | Mailbox interrupt enable |
| l_sel_n | input | 1 | Left chip select, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_we_n | input | 1 | Left write strobe, active low |
| l_hold_n | input | 1 | Left not-held-off status; 0 = held by arbiter |
| l_addr | input | 11 | Left address |
| r_sel_n | input | 1 | Right chip select, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_we_n | input | 1 | Right write strobe, active low |
| r_hold_n | input | 1 | Right not-held-off status; 0 = held by arbiter |
| r_addr | input | 11 | Right address |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
The assertions assume that every control, hold and address input is a clean synchronous level that is settled at each rising edge. They also assume that a single sample is one complete access, so a strobe held over several edges counts as repeated accesses. The stimulus respects this by changing inputs only at falling edges. Every pattern is held for exactly one cycle and then returned to idle, except where a back-to-back case is the point of the test.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int ADDR_W_DEF = 11;
  localparam int NUM_PORTS  = 2;
  localparam int LEFT_IDX   = 0;
  localparam int RIGHT_IDX  = 1;
endpackage

// File: rtl/mbox_port_decode.sv
module mbox_port_decode #(
  parameter int ADDR_W = mbox_pkg::ADDR_W_DEF,
  parameter logic [ADDR_W-1:0] OWN_BOX  = '0,
  parameter logic [ADDR_W-1:0] PEER_BOX = '0
) (
  input  logic              sel_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              hold_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              raise_peer,
  output logic              clear_own
);
  logic active;

  // A held-off port performs no mailbox side effect at all.
  always_comb begin
    active     = !sel_n && hold_n;
    raise_peer = active && !we_n && (addr == PEER_BOX);
    clear_own  = active && !oe_n && (addr == OWN_BOX);
  end
endmodule

// File: rtl/mbox_flag.sv
module mbox_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_q;

  // Priority: disable, then set, then clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (!en)    flag_q <= 1'b0;
    else if (set)    flag_q <= 1'b1;
    else if (clr)    flag_q <= 1'b0;
  end

  assign flag = flag_q;

  AST_SET_OVER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (en && set && clr) |=> flag); // R6
endmodule

// File: rtl/dual_port_mailbox_irq.sv
module dual_port_mailbox_irq #(
  parameter int ADDR_W = mbox_pkg::ADDR_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_en,
  input  logic              l_sel_n,
  input  logic              l_oe_n,
  input  logic              l_we_n,
  input  logic              l_hold_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_sel_n,
  input  logic              r_oe_n,
  input  logic              r_we_n,
  input  logic              r_hold_n,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              l_irq_n,
  output logic              r_irq_n
);
  import mbox_pkg::*;

  localparam logic [ADDR_W-1:0] RIGHT_BOX = '1;
  localparam logic [ADDR_W-1:0] LEFT_BOX  = RIGHT_BOX - 1'b1;

  logic [NUM_PORTS-1:0] sel_n_a, oe_n_a, we_n_a, hold_n_a;
  logic [ADDR_W-1:0]    addr_a [NUM_PORTS];
  logic [NUM_PORTS-1:0] raise_a, clear_a, flag_a;

  assign sel_n_a  = {r_sel_n,  l_sel_n};
  assign oe_n_a   = {r_oe_n,   l_oe_n};
  assign we_n_a   = {r_we_n,   l_we_n};
  assign hold_n_a = {r_hold_n, l_hold_n};
  assign addr_a[LEFT_IDX]  = l_addr;
  assign addr_a[RIGHT_IDX] = r_addr;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic [ADDR_W-1:0] OWN  = (p == LEFT_IDX) ? LEFT_BOX  : RIGHT_BOX;
    localparam logic [ADDR_W-1:0] PEER = (p == LEFT_IDX) ? RIGHT_BOX : LEFT_BOX;

    mbox_port_decode #(.ADDR_W(ADDR_W), .OWN_BOX(OWN), .PEER_BOX(PEER)) u_dec (
      .sel_n(sel_n_a[p]), .oe_n(oe_n_a[p]), .we_n(we_n_a[p]),
      .hold_n(hold_n_a[p]), .addr(addr_a[p]),
      .raise_peer(raise_a[p]), .clear_own(clear_a[p])
    );

    // A flag is raised by the other port and cleared by its owner.
    mbox_flag u_flag (
      .clk(clk), .rst_n(rst_n), .en(irq_en),
      .set(raise_a[NUM_PORTS-1-p]), .clr(clear_a[p]), .flag(flag_a[p])
    );
  end

  assign l_irq_n = ~flag_a[LEFT_IDX];
  assign r_irq_n = ~flag_a[RIGHT_IDX];

  logic l_hits_r, r_hits_l;
  assign l_hits_r = irq_en && !l_sel_n && !l_we_n && l_hold_n && (l_addr == RIGHT_BOX);
  assign r_hits_l = irq_en && !r_sel_n && !r_we_n && r_hold_n && (r_addr == LEFT_BOX);

  AST_RIGHT_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    l_hits_r |=> !r_irq_n); // R1
  AST_LEFT_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    r_hits_l |=> !l_irq_n); // R2
  AST_LEFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && !l_sel_n && !l_oe_n && l_hold_n && l_addr == LEFT_BOX && !r_hits_l)
    |=> l_irq_n); // R3
  AST_RIGHT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && !r_sel_n && !r_oe_n && r_hold_n && r_addr == RIGHT_BOX && !l_hits_r)
    |=> r_irq_n); // R4
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && !l_hold_n && !r_hits_l) |=> $stable(l_irq_n)); // R5
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> (l_irq_n && r_irq_n)); // R8
endmodule

// File: tb/dual_port_mailbox_irq_test.sv
module dual_port_mailbox_irq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_en = 1'b1;
  logic l_sel_n = 1'b1, l_oe_n = 1'b1, l_we_n = 1'b1, l_hold_n = 1'b1;
  logic r_sel_n = 1'b1, r_oe_n = 1'b1, r_we_n = 1'b1, r_hold_n = 1'b1;
  logic [10:0] l_addr = '0, r_addr = '0;
  logic l_irq_n, r_irq_n;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  int m_left = 0;
  int m_right = 0;

  always #10 clk = ~clk;

  dual_port_mailbox_irq uut (
    .clk(clk), .rst_n(rst_n), .irq_en(irq_en),
    .l_sel_n(l_sel_n), .l_oe_n(l_oe_n), .l_we_n(l_we_n), .l_hold_n(l_hold_n), .l_addr(l_addr),
    .r_sel_n(r_sel_n), .r_oe_n(r_oe_n), .r_we_n(r_we_n), .r_hold_n(r_hold_n), .r_addr(r_addr),
    .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
  );

  task automatic compare(input string tag);
    int exp_l, exp_r;
    exp_l = m_left  ? 0 : 1;
    exp_r = m_right ? 0 : 1;
    tests++;
    if (l_irq_n !== exp_l[0] || r_irq_n !== exp_r[0]) begin
      fails++;
      $display("FAIL %s: l_irq_n=%b r_irq_n=%b expected %0d %0d",
               tag, l_irq_n, r_irq_n, exp_l, exp_r);
    end
  endtask

  // Applies one cycle of stimulus, advances the model at the edge, then checks.
  task automatic step(
    input bit ls, input bit lo, input bit lw, input bit lh, input int la,
    input bit rs, input bit ro, input bit rw, input bit rh, input int ra,
    input bit en, input string tag);
    bit set_l, clr_l, set_r, clr_r;
    l_sel_n = ls; l_oe_n = lo; l_we_n = lw; l_hold_n = lh; l_addr = la[10:0];
    r_sel_n = rs; r_oe_n = ro; r_we_n = rw; r_hold_n = rh; r_addr = ra[10:0];
    irq_en = en;
    @(posedge clk);
    set_l = (rs == 0) && (rw == 0) && rh && (ra == 'h7FE);
    clr_l = (ls == 0) && (lo == 0) && lh && (la == 'h7FE);
    set_r = (ls == 0) && (lw == 0) && lh && (la == 'h7FF);
    clr_r = (rs == 0) && (ro == 0) && rh && (ra == 'h7FF);
    if (!en) begin
      m_left = 0; m_right = 0;
    end else begin
      if (set_l) m_left = 1; else if (clr_l) m_left = 0;
      if (set_r) m_right = 1; else if (clr_r) m_right = 0;
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input string tag);
    step(1,1,1,1,0, 1,1,1,1,0, 1, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R7 reset held");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R7 after reset");

    step(0,1,0,1,'h7FF, 1,1,1,1,0, 1, "R1 left writes right mailbox");
    idle("R9 idle keeps flag");
    step(0,1,0,1,'h7FE, 1,1,1,1,0, 1, "R9 left writes own mailbox");
    step(1,1,1,1,0, 0,0,1,0,'h7FF, 1, "R5 right clear while held");
    step(1,1,1,1,0, 0,1,1,1,'h7FF, 1, "R9 right select without output enable");
    step(1,1,1,1,0, 0,0,1,1,'h7FF, 1, "R4 right reads own mailbox");
    step(1,1,1,1,0, 0,1,0,1,'h7FE, 1, "R2 right writes left mailbox");
    step(0,0,0,1,'h7FE, 1,1,1,1,0, 1, "R3 left clears with write low");
    step(1,1,1,1,0, 0,1,0,0,'h7FE, 1, "R5 right set while held");
    step(0,0,1,1,'h7FE, 0,1,0,1,'h7FE, 1, "R6 set and clear same cycle");
    step(0,0,1,0,'h7FE, 1,1,1,1,0, 1, "R5 left clear while held");
    step(0,0,1,1,'h7FE, 1,1,1,1,0, 1, "R3 left reads own mailbox");
    step(0,1,0,1,'h7FD, 0,1,0,1,'h7FD, 1, "R9 other address writes");
    step(0,1,0,1,'h7FF, 0,1,0,1,'h7FE, 1, "R1 R2 both raise");
    step(1,1,1,1,0, 1,1,1,1,0, 0, "R8 disable clears");
    step(0,1,0,1,'h7FF, 0,1,0,1,'h7FE, 0, "R8 disabled writes ignored");
    idle("R8 re-enable quiet");
    step(0,1,0,1,'h7FF, 1,1,1,1,0, 1, "R1 raise after re-enable");
    step(0,1,0,1,'h7FF, 0,0,1,1,'h7FF, 1, "R6 right set beats clear");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule